// File: doc/BRIEF.md
# APB Multi-Completer Ready Return

This block sits between a single APB manager and a set of completers. It decodes the manager's address into one select line per completer. It passes the phase, address, direction and write data straight through to every completer. It then returns to the manager the ready, read data and error response of the completer that is addressed, and of no other.

An idle completer can never hold up the transfer, because only the selected completer's ready reaches the manager. An address that falls in no completer window does not hang. The block answers it with an error completion of its own on the first access cycle.

A bus-level monitor watches every completer. A completer breaks the rule if its select is low and its ready output is low in the same cycle. The monitor raises a sticky flag and reports the lowest index among all completers that have broken the rule since reset. The flag and index stay until reset and show which completer misbehaves, even though the manager was never stalled by it.

Top module: `apb_ready_return`

## Requirements
- R1: Completer i owns the address window [base_i, base_i + size_i). With the default parameters the windows are 0x000–0x0FF (0), 0x100–0x1FF (1), 0x200–0x27F (2) and 0x300–0x3FF (3). `cPsel[i]` is high exactly when `mPsel` is high and `mPaddr` lies in window i, and at most one bit of `cPsel` is high.
- R2: `cPenable`, `cPaddr`, `cPwrite` and `cPwdata` equal the manager's `mPenable`, `mPaddr`, `mPwrite` and `mPwdata` in the same cycle.
- R3: While completer i is selected, `mPready`, `mPrdata` and `mPslverr` equal that completer's ready, read data slice (bits i*DATA_W upward) and error bit.
- R4: A completer whose select is low has no effect on `mPready`, even when its ready output is 0.
- R5: For an address in no window, `mPready` is 1 in both setup and access. `mPslverr` is 0 in setup. On the access cycle (`mPenable`=1), `mPslverr` is 1 and `mPrdata` is 0, so the transfer ends after one access cycle.
- R6: While `mPsel` is low, `mPready` is 1, `mPslverr` is 0 and `mPrdata` is 0.
- R7: If any completer has `cPsel[i]`=0 and `cPready[i]`=0 at a clock edge, `violFlag` is 1 from the next cycle and stays 1 until reset. A completer that is selected and not ready never raises the flag.
- R8: `violIdx` is the lowest index among all completers that have broken the rule of R7 since reset. It is 0 while `violFlag` is 0.
- R9: During and right after reset (`presetn` low, active-low, asynchronous), `violFlag` and `violIdx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| mPsel | input | 1 | Manager select |
| mPenable | input | 1 | Manager access phase |
| mPaddr | input | ADDR_W | Manager address |
| mPwrite | input | 1 | Manager write direction |
| mPwdata | input | DATA_W | Manager write data |
| mPready | output | 1 | Returned ready |
| mPrdata | output | DATA_W | Returned read data |
| mPslverr | output | 1 | Returned error |
| cPsel | output | NUM_TGT | Per-completer select |
| cPenable | output | 1 | Forwarded access phase |
| cPaddr | output | ADDR_W | Forwarded address |
| cPwrite | output | 1 | Forwarded direction |
| cPwdata | output | DATA_W | Forwarded write data |
| cPready | input | NUM_TGT | Per-completer ready |
| cPrdata | input | NUM_TGT*DATA_W | Per-completer read data, completer i in bits i*DATA_W upward |
| cPslverr | input | NUM_TGT | Per-completer error |
| violFlag | output | 1 | Sticky idle-ready violation flag |
| violIdx | output | IDX_W | Lowest violating completer index |

## Verification
The assertions check on every cycle that:
- at most one completer is selected;
- the return follows the selected completer;
- idle and unmapped returns take their fixed values;
- the flag rises after any idle completer drops its ready, and never falls;
- the reported index never grows once set.

Only the bench scenarios can show the rest:
- the exact window edges, which come from an address sweep;
- the running minimum moving down to a lower completer;
- a selected completer held not ready leaving the flag clear;
- reset clearing a set flag.

// File: rtl/apb_ret_pkg.sv
`timescale 1ns/1ps
package apb_ret_pkg;

  // Strobes from the decode control to the return datapath.
  typedef struct packed {
    logic idle;       // no transfer on the bus
    logic hit;        // transfer addresses a mapped completer
    logic errAccess;  // unmapped address, access phase
  } retCtrl_t;

endpackage

// File: rtl/apbRetDecode.sv
`timescale 1ns/1ps
module apbRetDecode
  import apb_ret_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 2,
  parameter logic [NUM_TGT*ADDR_W-1:0] BASE_LIST = '0,
  parameter logic [NUM_TGT*ADDR_W-1:0] SIZE_LIST = '0
) (
  input  logic               mPsel,
  input  logic               mPenable,
  input  logic [ADDR_W-1:0]  mPaddr,
  output logic [NUM_TGT-1:0] cPsel,
  output logic [IDX_W-1:0]   selIdx,
  output retCtrl_t           ctrl
);

  logic [NUM_TGT-1:0] hitVec;
  logic               found;

  // One window comparator per completer; widened by a bit so base+size cannot wrap.
  for (genvar i = 0; i < NUM_TGT; i++) begin : g_win
    localparam logic [ADDR_W-1:0] WIN_BASE = BASE_LIST[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] WIN_SIZE = SIZE_LIST[i*ADDR_W +: ADDR_W];
    logic [ADDR_W:0] addrWide;
    logic [ADDR_W:0] loBound;
    logic [ADDR_W:0] hiBound;
    assign addrWide  = {1'b0, mPaddr};
    assign loBound   = {1'b0, WIN_BASE};
    assign hiBound   = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
    assign hitVec[i] = (addrWide >= loBound) && (addrWide < hiBound);
  end

  // Lowest-index hit wins, so overlapping windows still give a single select.
  always_comb begin
    selIdx = '0;
    found  = 1'b0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TGT; i++) begin
      cPsel[i] = mPsel && found && (selIdx == IDX_W'(i));
    end
  end

  always_comb begin
    ctrl.idle      = !mPsel;
    ctrl.hit       = mPsel && found;
    ctrl.errAccess = mPsel && !found && mPenable;
  end

endmodule

// File: rtl/apbRetMux.sv
`timescale 1ns/1ps
module apbRetMux
  import apb_ret_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input  retCtrl_t                   ctrl,
  input  logic [IDX_W-1:0]           selIdx,
  input  logic [NUM_TGT-1:0]         cPready,
  input  logic [NUM_TGT*DATA_W-1:0]  cPrdata,
  input  logic [NUM_TGT-1:0]         cPslverr,
  output logic                       mPready,
  output logic [DATA_W-1:0]          mPrdata,
  output logic                       mPslverr
);

  logic              pickReady;
  logic [DATA_W-1:0] pickData;
  logic              pickErr;

  // Select the addressed completer's return; other completers never reach the output.
  always_comb begin
    pickReady = 1'b1;
    pickData  = '0;
    pickErr   = 1'b0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (selIdx == IDX_W'(i)) begin
        pickReady = cPready[i];
        pickData  = cPrdata[i*DATA_W +: DATA_W];
        pickErr   = cPslverr[i];
      end
    end
  end

  always_comb begin
    mPready  = 1'b1;
    mPrdata  = '0;
    mPslverr = 1'b0;
    if (ctrl.hit) begin
      mPready  = pickReady;
      mPrdata  = pickData;
      mPslverr = pickErr;
    end else if (ctrl.errAccess) begin
      mPslverr = 1'b1;
    end
  end

endmodule

// File: rtl/apbRetReadyMon.sv
`timescale 1ns/1ps
module apbRetReadyMon #(
  parameter int NUM_TGT = 4,
  parameter int IDX_W   = 2
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic [NUM_TGT-1:0] cPsel,
  input  logic [NUM_TGT-1:0] cPready,
  output logic               violFlag,
  output logic [IDX_W-1:0]   violIdx
);

  logic [NUM_TGT-1:0] seenMask;
  logic [NUM_TGT-1:0] offendNow;

  assign offendNow = ~cPsel & ~cPready;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) seenMask <= '0;
    else          seenMask <= seenMask | offendNow;
  end

  assign violFlag = |seenMask;

  // The lowest bit set in the sticky mask gives the running minimum index.
  always_comb begin
    violIdx = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (seenMask[i]) violIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/apb_ready_return.sv
`timescale 1ns/1ps
module apb_ready_return
  import apb_ret_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter logic [NUM_TGT*ADDR_W-1:0] BASE_LIST = {12'h300, 12'h200, 12'h100, 12'h000},
  parameter logic [NUM_TGT*ADDR_W-1:0] SIZE_LIST = {12'h100, 12'h080, 12'h100, 12'h100},
  localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                      pclk,
  input  logic                      presetn,
  input  logic                      mPsel,
  input  logic                      mPenable,
  input  logic [ADDR_W-1:0]         mPaddr,
  input  logic                      mPwrite,
  input  logic [DATA_W-1:0]         mPwdata,
  output logic                      mPready,
  output logic [DATA_W-1:0]         mPrdata,
  output logic                      mPslverr,
  output logic [NUM_TGT-1:0]        cPsel,
  output logic                      cPenable,
  output logic [ADDR_W-1:0]         cPaddr,
  output logic                      cPwrite,
  output logic [DATA_W-1:0]         cPwdata,
  input  logic [NUM_TGT-1:0]        cPready,
  input  logic [NUM_TGT*DATA_W-1:0] cPrdata,
  input  logic [NUM_TGT-1:0]        cPslverr,
  output logic                      violFlag,
  output logic [IDX_W-1:0]          violIdx
);

  retCtrl_t         ctrl;
  logic [IDX_W-1:0] selIdx;

  assign cPenable = mPenable;
  assign cPaddr   = mPaddr;
  assign cPwrite  = mPwrite;
  assign cPwdata  = mPwdata;

  apbRetDecode #(
    .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .BASE_LIST(BASE_LIST), .SIZE_LIST(SIZE_LIST)
  ) decode_i (
    .mPsel(mPsel), .mPenable(mPenable), .mPaddr(mPaddr),
    .cPsel(cPsel), .selIdx(selIdx), .ctrl(ctrl)
  );

  apbRetMux #(
    .NUM_TGT(NUM_TGT), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) mux_i (
    .ctrl(ctrl), .selIdx(selIdx),
    .cPready(cPready), .cPrdata(cPrdata), .cPslverr(cPslverr),
    .mPready(mPready), .mPrdata(mPrdata), .mPslverr(mPslverr)
  );

  apbRetReadyMon #(
    .NUM_TGT(NUM_TGT), .IDX_W(IDX_W)
  ) mon_i (
    .pclk(pclk), .presetn(presetn),
    .cPsel(cPsel), .cPready(cPready),
    .violFlag(violFlag), .violIdx(violIdx)
  );

endmodule

// File: rtl/apb_ready_return_chk.sv
`timescale 1ns/1ps
module apb_ready_return_chk #(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input logic               pclk,
  input logic               presetn,
  input logic               mPsel,
  input logic               mPenable,
  input logic               mPready,
  input logic [DATA_W-1:0]  mPrdata,
  input logic               mPslverr,
  input logic [NUM_TGT-1:0] cPsel,
  input logic [NUM_TGT-1:0] cPready,
  input logic [NUM_TGT-1:0] cPslverr,
  input logic               violFlag,
  input logic [IDX_W-1:0]   violIdx
);

  AST_ONE_SELECT: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(cPsel)); // R1

  AST_SEL_NEEDS_MGR: assert property (@(posedge pclk) disable iff (!presetn)
    (cPsel != '0) |-> mPsel); // R1

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_route
    AST_RETURN_ROUTE: assert property (@(posedge pclk) disable iff (!presetn)
      cPsel[k] |-> (mPready == cPready[k] && mPslverr == cPslverr[k])); // R3
  end

  AST_UNMAPPED_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (mPsel && mPenable && cPsel == '0) |-> (mPready && mPslverr && mPrdata == '0)); // R5

  AST_IDLE_RETURN: assert property (@(posedge pclk) disable iff (!presetn)
    !mPsel |-> (mPready && !mPslverr && mPrdata == '0)); // R6

  AST_VIOL_DETECT: assert property (@(posedge pclk) disable iff (!presetn)
    ((~cPsel & ~cPready) != '0) |=> violFlag); // R7

  AST_VIOL_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    violFlag |=> violFlag); // R7

  AST_IDX_NO_RISE: assert property (@(posedge pclk) disable iff (!presetn)
    violFlag |=> (violIdx <= $past(violIdx))); // R8

  AST_IDX_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    !violFlag |-> (violIdx == '0)); // R8

endmodule

bind apb_ready_return apb_ready_return_chk #(
  .NUM_TGT(NUM_TGT), .DATA_W(DATA_W), .IDX_W(IDX_W)
) chk_i (
  .pclk(pclk), .presetn(presetn),
  .mPsel(mPsel), .mPenable(mPenable),
  .mPready(mPready), .mPrdata(mPrdata), .mPslverr(mPslverr),
  .cPsel(cPsel), .cPready(cPready), .cPslverr(cPslverr),
  .violFlag(violFlag), .violIdx(violIdx)
);

// File: tb/apb_ready_return_tb_top.sv
`timescale 1ns/1ps
module apb_ready_return_tb_top;

  localparam int NT = 4;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          mPsel = 1'b0;
  logic          mPenable = 1'b0;
  logic [AW-1:0] mPaddr = '0;
  logic          mPwrite = 1'b0;
  logic [DW-1:0] mPwdata = '0;
  logic          mPready;
  logic [DW-1:0] mPrdata;
  logic          mPslverr;
  logic [NT-1:0] cPsel;
  logic          cPenable;
  logic [AW-1:0] cPaddr;
  logic          cPwrite;
  logic [DW-1:0] cPwdata;
  logic [NT-1:0] cPready = '1;
  logic [NT*DW-1:0] cPrdata = '0;
  logic [NT-1:0] cPslverr = '0;
  logic          violFlag;
  logic [1:0]    violIdx;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 pclk = ~pclk;

  apb_ready_return dut_i (
    .pclk(pclk), .presetn(presetn),
    .mPsel(mPsel), .mPenable(mPenable), .mPaddr(mPaddr),
    .mPwrite(mPwrite), .mPwdata(mPwdata),
    .mPready(mPready), .mPrdata(mPrdata), .mPslverr(mPslverr),
    .cPsel(cPsel), .cPenable(cPenable), .cPaddr(cPaddr),
    .cPwrite(cPwrite), .cPwdata(cPwdata),
    .cPready(cPready), .cPrdata(cPrdata), .cPslverr(cPslverr),
    .violFlag(violFlag), .violIdx(violIdx)
  );

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Window map from R1.
  function automatic int expSel(input int a);
    if (a < 'h100) return 0;
    if (a < 'h200) return 1;
    if (a < 'h280) return 2;
    if (a >= 'h300 && a < 'h400) return 3;
    return -1;
  endfunction

  task automatic doReset();
    @(negedge pclk);
    presetn = 1'b0;
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    #1;
    chkEq("R9 flag in reset", 32'(violFlag), 0);
    chkEq("R9 idx in reset", 32'(violIdx), 0);
    @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    #1;
    chkEq("R9 flag after reset", 32'(violFlag), 0);
    chkEq("R9 idx after reset", 32'(violIdx), 0);
  endtask

  // Access to completer 1 with a chosen ready vector, held for one cycle.
  task automatic violCycle(input logic [NT-1:0] rdy);
    @(negedge pclk);
    mPsel = 1'b1; mPenable = 1'b1; mPaddr = 12'h140;
    cPready = rdy;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge pclk);
    doReset();

    // Address sweep across all windows and the unmapped space.
    for (int a = 0; a < 4096; a += 32) begin
      int s;
      logic selRdy;
      logic [NT-1:0] expVec;
      s = expSel(a);
      selRdy = 1'((a >> 5) & 1);
      expVec = (s >= 0) ? NT'(1 << s) : '0;
      @(negedge pclk);
      mPsel = 1'b1; mPenable = 1'b0; mPaddr = AW'(a);
      mPwrite = 1'((a >> 6) & 1); mPwdata = 32'h5A00_0000 | 32'(a);
      cPready = '1;
      if (s >= 0) cPready[s] = selRdy;
      for (int k = 0; k < NT; k++) begin
        cPrdata[k*DW +: DW] = 32'hA000_0000 | (32'(k) << 16) | 32'(a);
        cPslverr[k] = 1'(((a >> 6) & 1) ^ (k & 1));
      end
      #1;
      chkEq("R1 select decode", 32'(cPsel), 32'(expVec));
      chkEq("R2 paddr fwd", 32'(cPaddr), 32'(a));
      chkEq("R2 penable fwd setup", 32'(cPenable), 0);
      chkEq("R2 pwrite fwd", 32'(cPwrite), (a >> 6) & 1);
      if (s >= 0) chkEq("R3 setup ready", 32'(mPready), 32'(selRdy));
      else begin
        chkEq("R5 setup ready", 32'(mPready), 1);
        chkEq("R5 setup no error", 32'(mPslverr), 0);
      end

      @(negedge pclk);
      mPenable = 1'b1;
      #1;
      chkEq("R2 penable fwd access", 32'(cPenable), 1);
      chkEq("R2 pwdata fwd", cPwdata, 32'h5A00_0000 | 32'(a));
      if (s >= 0) begin
        chkEq("R3 ready", 32'(mPready), 32'(selRdy));
        chkEq("R3 rdata", mPrdata, 32'hA000_0000 | (32'(s) << 16) | 32'(a));
        chkEq("R3 slverr", 32'(mPslverr), ((a >> 6) & 1) ^ (s & 1));
      end else begin
        chkEq("R5 error ready", 32'(mPready), 1);
        chkEq("R5 error slverr", 32'(mPslverr), 1);
        chkEq("R5 error rdata", mPrdata, 0);
      end

      @(negedge pclk);
      mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
      #1;
      chkEq("R6 idle ready", 32'(mPready), 1);
      chkEq("R6 idle slverr", 32'(mPslverr), 0);
      chkEq("R6 idle rdata", mPrdata, 0);
      chkEq("R1 idle no select", 32'(cPsel), 0);
    end
    chkEq("R7 no flag after clean sweep", 32'(violFlag), 0);

    // R4: idle completer 3 not ready, selected completer 1 ready.
    cPslverr = 4'b0010;
    violCycle(4'b0111);
    #1;
    chkEq("R4 idle low ignored ready", 32'(mPready), 1);
    chkEq("R4 idle low ignored slverr", 32'(mPslverr), 1);
    @(negedge pclk);
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    #1;
    chkEq("R7 flag raised", 32'(violFlag), 1);
    chkEq("R8 idx first offender", 32'(violIdx), 3);

    // R8: lower offender 2 moves the index down.
    violCycle(4'b1011);
    @(negedge pclk);
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    #1;
    chkEq("R8 idx moves to lower", 32'(violIdx), 2);

    // R8: a higher offender does not move it back up.
    violCycle(4'b0111);
    #1;
    chkEq("R4 selected ready passes", 32'(mPready), 1);
    @(negedge pclk);
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    repeat (3) @(negedge pclk);
    #1;
    chkEq("R8 idx keeps minimum", 32'(violIdx), 2);
    chkEq("R7 flag sticky", 32'(violFlag), 1);

    // R9: reset clears a set flag.
    doReset();

    // R7: a selected completer holding ready low is not a violation.
    for (int c = 0; c < 4; c++) begin
      violCycle(4'b1101);
      #1;
      chkEq("R3 selected low stalls", 32'(mPready), 0);
    end
    @(negedge pclk);
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    #1;
    chkEq("R7 selected low no flag", 32'(violFlag), 0);

    // R8: completer 0 offends; index 0 with the flag set.
    violCycle(4'b1110);
    @(negedge pclk);
    mPsel = 1'b0; mPenable = 1'b0; cPready = '1;
    #1;
    chkEq("R7 flag from completer 0", 32'(violFlag), 1);
    chkEq("R8 idx completer 0", 32'(violIdx), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule